// File: doc/BRIEF.md
# Blinking Arrow Sign Sequencer

This block is the controller for a five-lamp directional warning sign. The lamps are driven in three groups: lamps 1 and 2 together, lamps 3 and 4 together, and lamp 5 alone. While the operate switch is on, the sign builds up an arrow in four repeating phases. First it is dark. Then the first pair lights, then both pairs, then all five lamps, and then it goes dark again. When the switch is off, the sign stays dark.

The sequencer is a Moore machine. A two-bit phase register holds the phase, and the lamp enables are decoded from that register alone. The blink rate is set by the parameter `STEP_CLKS`, the number of clocks each phase lasts. With the default of 1 the phase advances on every clock. A larger value makes a step pacer that lets the phase advance once every `STEP_CLKS` clocks of continuous operation. The step pacer is cleared whenever the switch is off.

Top module: `arrow_sign_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the phase becomes dark (00) and all three lamp enables are low after that edge, whatever `run_sw` is.
- R2: With `run_sw` held high and `STEP_CLKS` = 1, the phase advances once per clock through 00, 01, 10, 11 and then wraps back to 00.
- R3: At any clock edge where `run_sw` is low, the next phase is 00 (all lamps dark), from any phase and whatever the step pacer holds.
- R4: `lamp_12` is high exactly in phases 01, 10 and 11.
- R5: `lamp_34` is high exactly in phases 10 and 11. It is never high while `lamp_12` is low.
- R6: `lamp_5` is high only in phase 11. It is never high while `lamp_34` is low.
- R7: With `STEP_CLKS` = N > 1 and `run_sw` held high, the phase advances on the Nth clock edge after the switch is seen high and then on every Nth edge after that. It is unchanged on all other edges.
- R8: An edge with `run_sw` low clears the step pacer. When the switch comes back on, a fresh count of N edges starts before the first advance.
- R9: The lamp enables depend only on the registered phase. A change on `run_sw` between clock edges does not change them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the phase register updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run_sw | input | 1 | Operate switch; high lets the sequence run |
| lamp_12 | output | 1 | Enable for lamps 1 and 2 |
| lamp_34 | output | 1 | Enable for lamps 3 and 4 |
| lamp_5 | output | 1 | Enable for lamp 5 |

## Verification
Two instances run side by side, one at the default rate and one at three clocks per phase. A cycle-accurate model in the bench predicts both. The bench turns the switch off in the middle of the 10 and 11 phases and in the middle of a pacer count. A design that only dropped to the previous phase, or that kept a stale pacer count, would then show lamps lit one cycle too long or advance early after the restart. The bench also holds the switch on across several full cycles, so that a wrong wrap from 11 to 00 or a skipped phase shows up as a lamp pattern that does not match. Between clock edges the bench flips the switch and checks that the lamps do not move, which catches any decode that reads `run_sw` directly.

// File: rtl/arrow_sign_pkg.sv
package arrow_sign_pkg;

  typedef enum logic [1:0] {
    PH_DARK = 2'b00,
    PH_PAIR = 2'b01,
    PH_QUAD = 2'b10,
    PH_FULL = 2'b11
  } phase_t;

  typedef struct packed {
    logic g12;
    logic g34;
    logic g5;
  } lamp_t;

  function automatic phase_t phase_advance(input phase_t p);
    case (p)
      PH_DARK: phase_advance = PH_PAIR;
      PH_PAIR: phase_advance = PH_QUAD;
      PH_QUAD: phase_advance = PH_FULL;
      default: phase_advance = PH_DARK;
    endcase
  endfunction

  function automatic lamp_t lamps_of(input phase_t p);
    lamp_t l;
    case (p)
      PH_PAIR: l = '{g12: 1'b1, g34: 1'b0, g5: 1'b0};
      PH_QUAD: l = '{g12: 1'b1, g34: 1'b1, g5: 1'b0};
      PH_FULL: l = '{g12: 1'b1, g34: 1'b1, g5: 1'b1};
      default: l = '{g12: 1'b0, g34: 1'b0, g5: 1'b0};
    endcase
    return l;
  endfunction

endpackage

// File: rtl/arrow_step_pacer.sv
module arrow_step_pacer #(
  parameter int STEP_CLKS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run_sw,
  output logic step_tick
);
  localparam int CNT_W = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CLKS - 1);

  logic [CNT_W-1:0] cnt;
  logic             at_last;

  assign at_last   = (cnt == LAST);
  assign step_tick = run_sw && at_last;

  always_ff @(posedge clk) begin
    if (rst || !run_sw) begin
      cnt <= '0;
    end else if (at_last) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_TICK_NEEDS_SWITCH: assert property (@(posedge clk) disable iff (rst)
    step_tick |-> run_sw); // R7
  AST_PACER_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R7
  AST_PACER_CLEARED: assert property (@(posedge clk) disable iff (rst)
    !run_sw |=> cnt == '0); // R8

endmodule

// File: rtl/arrow_phase_reg.sv
module arrow_phase_reg
  import arrow_sign_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   run_sw,
  input  logic   step_tick,
  output phase_t phase
);

  always_ff @(posedge clk) begin
    if (rst || !run_sw) begin
      phase <= PH_DARK;
    end else if (step_tick) begin
      phase <= phase_advance(phase);
    end
  end

  AST_OFF_GOES_DARK: assert property (@(posedge clk) disable iff (rst)
    !run_sw |=> phase == PH_DARK); // R3
  AST_FULL_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (run_sw && step_tick && phase == PH_FULL) |=> phase == PH_DARK); // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (run_sw && !step_tick) |=> $stable(phase)); // R7

endmodule

// File: rtl/arrow_lamp_decode.sv
module arrow_lamp_decode
  import arrow_sign_pkg::*;
(
  input  phase_t phase,
  output logic   g12,
  output logic   g34,
  output logic   g5
);
  lamp_t lamps;

  always_comb begin
    lamps = lamps_of(phase);
    g12   = lamps.g12;
    g34   = lamps.g34;
    g5    = lamps.g5;
  end

endmodule

// File: rtl/arrow_sign_seq.sv
module arrow_sign_seq
  import arrow_sign_pkg::*;
#(
  parameter int STEP_CLKS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run_sw,
  output logic lamp_12,
  output logic lamp_34,
  output logic lamp_5
);
  logic   step_tick;
  phase_t phase;

  arrow_step_pacer #(.STEP_CLKS(STEP_CLKS)) u_pacer (
    .clk       (clk),
    .rst       (rst),
    .run_sw    (run_sw),
    .step_tick (step_tick)
  );

  arrow_phase_reg u_phase (
    .clk       (clk),
    .rst       (rst),
    .run_sw    (run_sw),
    .step_tick (step_tick),
    .phase     (phase)
  );

  arrow_lamp_decode u_decode (
    .phase (phase),
    .g12   (lamp_12),
    .g34   (lamp_34),
    .g5    (lamp_5)
  );

  AST_RESET_DARK: assert property (@(posedge clk)
    rst |=> (!lamp_12 && !lamp_34 && !lamp_5)); // R1
  AST_PAIR34_NEEDS_12: assert property (@(posedge clk) disable iff (rst)
    lamp_34 |-> lamp_12); // R5
  AST_LAMP5_NEEDS_34: assert property (@(posedge clk) disable iff (rst)
    lamp_5 |-> lamp_34); // R6
  AST_DARK_ONLY_IN_00: assert property (@(posedge clk) disable iff (rst)
    lamp_12 == (phase != PH_DARK)); // R4

endmodule

// File: tb/arrow_sign_seq_tb.sv
module arrow_sign_seq_tb;
  localparam int SLOW_N = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_sw = 1'b0;
  logic f12, f34, f5, s12, s34, s5;

  always #4 clk = ~clk;

  arrow_sign_seq #(.STEP_CLKS(1)) u_dut (
    .clk(clk), .rst(rst), .run_sw(run_sw),
    .lamp_12(f12), .lamp_34(f34), .lamp_5(f5));

  arrow_sign_seq #(.STEP_CLKS(SLOW_N)) u_dut_slow (
    .clk(clk), .rst(rst), .run_sw(run_sw),
    .lamp_12(s12), .lamp_34(s34), .lamp_5(s5));

  typedef struct {
    logic [2:0] fast;
    logic [2:0] slow;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model: level 0..3 counts lit steps
  int f_lvl = 0, s_lvl = 0, s_cnt = 0;

  function automatic logic [2:0] pattern(input int lvl);
    return {lvl >= 1, lvl >= 2, lvl >= 3};
  endfunction

  task automatic compare(input logic [2:0] act, input logic [2:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  // driver: called just after a falling edge; one call = one clock
  task automatic step(input logic sw, input logic r, input string tag);
    exp_t e;
    logic [2:0] hold_f, hold_s;
    hold_f = {f12, f34, f5};
    hold_s = {s12, s34, s5};
    run_sw = sw;
    rst    = r;
    #1;
    compare({f12, f34, f5}, hold_f, "R9 fast lamps moved between edges");
    compare({s12, s34, s5}, hold_s, "R9 slow lamps moved between edges");
    if (r || !sw) begin
      f_lvl = 0; s_lvl = 0; s_cnt = 0;
    end else begin
      f_lvl = (f_lvl + 1) % 4;
      if (s_cnt == SLOW_N - 1) begin
        s_cnt = 0;
        s_lvl = (s_lvl + 1) % 4;
      end else begin
        s_cnt++;
      end
    end
    e.fast = pattern(f_lvl);
    e.slow = pattern(s_lvl);
    e.tag  = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        compare({f12, f34, f5}, e.fast, {e.tag, " fast"});
        compare({s12, s34, s5}, e.slow, {e.tag, " slow"});
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset dominates even with switch on
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, "R1 reset dark");
    // R2 R4 R5 R6 R7: long run, fast wraps several times
    for (int i = 0; i < 14; i++) step(1'b1, 1'b0, "R2 R4 R5 R6 R7 run");
    // R3: switch off from mid sequence
    step(1'b0, 1'b0, "R3 off forces dark");
    step(1'b0, 1'b0, "R3 stays dark");
    // R3 from phase 10 (fast) after two on clocks
    step(1'b1, 1'b0, "R2 restart");
    step(1'b1, 1'b0, "R5 phase 10");
    step(1'b0, 1'b0, "R3 off from 10");
    // R8: slow pacer mid-count then off, then fresh count
    step(1'b1, 1'b0, "R8 partial count");
    step(1'b0, 1'b0, "R8 clear pacer");
    for (int i = 0; i < 7; i++) step(1'b1, 1'b0, "R8 R7 fresh count");
    // R3 from phase 11 (fast)
    step(1'b0, 1'b0, "R3 off from 11");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R6 reach 11");
    step(1'b0, 1'b0, "R3 off from 11 again");
    step(1'b0, 1'b0, "R3 hold dark");
    @(posedge clk);
    #3;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule